// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Startup Gating

This block sits beside the row-strobe control of a cached DRAM and turns the strobe, refresh and column-latch inputs into refresh requests for the array. Two kinds of refresh are recognised. A counter refresh is flagged by the refresh input at the rising edge of the row-active input and uses a row from an internal counter. An addressed refresh is a write-type cycle whose column latch never asserts, and it uses the row presented at the start of the cycle. Every input is an active-high version of the corresponding device pin, sampled on the block clock.

The block also decides when the cache tags may be rewritten. Only read cycles permit it, so refresh cycles and writes leave the tags untouched. Two misuse conditions are flagged: a read-type cycle that ends with no column latch, which the array would treat as a hit and not refresh, and any non-refresh cycle started while the chip is deselected. A window watchdog counts counter refreshes and raises a violation level when a window holds too few. A ready level stays low until a minimum number of active cycles has passed and every bank has then seen reads to two different rows.

Top module: `rfsh_seq`

## Requirements
- R1: When `rfsh_i` is high on the clock where `row_act_i` first rises, `arr_go_o` pulses on the next clock with `arr_kind_o`=0 and `arr_row_o` equal to the refresh counter. `addr_i`, `wr_sel_i`, `sel_i` and `col_latch_i` have no effect on that request.
- R2: The refresh counter starts at 0 after reset. It advances by one, wrapping modulo 2^ROW_W, when a counter refresh cycle ends (`row_act_i` falls), so successive counter refreshes use consecutive rows.
- R3: A cycle started with `rfsh_i` low, `sel_i` high and `wr_sel_i` high, in which `col_latch_i` is never high while `row_act_i` is high, produces an `arr_go_o` pulse on the clock after `row_act_i` falls. That pulse has `arr_kind_o`=1 and `arr_row_o` equal to `addr_i` captured at the start. If the column latch was seen, no request is made.
- R4: `tag_wr_ok_o` is high only during a read cycle (`rfsh_i` low, `sel_i` high, `wr_sel_i` low at the start), from the clock after the start until the clock after `row_act_i` falls. It stays low through counter refreshes, write cycles and idle time.
- R5: A counter refresh with `sel_i` low is legal and raises no error. Any other cycle started with `sel_i` low gives a one-clock `desel_err_o` pulse and makes no request.
- R6: A read cycle that ends with no `col_latch_i` seen gives a one-clock `rd_rfsh_err_o` pulse on the clock after `row_act_i` falls.
- R7: `viol_o` is 0 after reset and changes only at the last clock of each WIN_CYC-clock window, counted from reset. It becomes 1 if fewer than MIN_RFSH counter refreshes started in that window, and 0 otherwise.
- R8: `ready_o` rises only after INIT_CYC cycle starts have occurred. Reads started once that count is complete are then tracked per bank, the bank being the top two bits of `addr_i`. `ready_o` rises once every bank has had reads to two different rows, and it never falls until reset.
- R9: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_act_i | input | 1 | Row strobe active (high = asserted) |
| col_latch_i | input | 1 | Column latch asserted |
| wr_sel_i | input | 1 | Cycle type at start: 1 write, 0 read |
| rfsh_i | input | 1 | Counter refresh requested at start |
| sel_i | input | 1 | Chip selected |
| addr_i | input | ROW_W | Row address; top two bits choose the bank |
| arr_go_o | output | 1 | One-clock refresh request to the array |
| arr_kind_o | output | 1 | 0 counter refresh, 1 addressed refresh |
| arr_row_o | output | ROW_W | Row to refresh |
| tag_wr_ok_o | output | 1 | Cache tag update permitted |
| desel_err_o | output | 1 | Non-refresh cycle started while deselected |
| rd_rfsh_err_o | output | 1 | Read cycle ended with no column latch |
| viol_o | output | 1 | Last window had too few counter refreshes |
| ready_o | output | 1 | Startup sequence complete |

## Verification
On every cycle the assertions check several relations. Consecutive counter refresh requests carry consecutive rows. A counter refresh never coincides with a tag update permit. Deselect errors follow a deselected start, and addressed requests follow a fall of the strobe. The violation level moves only on window boundaries, and the ready level never drops and never rises before the required number of starts. Exact cycle timing needs the bench's scenarios and its per-clock model. So do the ignored inputs during counter refresh, counter wrap, the column-latch rule for addressed refresh and the bank-by-bank startup sequence, including the read that does not count because it arrives before the start count is complete.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Kind of active cycle, decided at the rising edge of the row strobe
    typedef enum logic [2:0] {
        CY_IDLE = 3'd0,
        CY_CTR  = 3'd1,
        CY_WR   = 3'd2,
        CY_RD   = 3'd3,
        CY_BAD  = 3'd4
    } cyc_e;

    typedef enum logic {
        RQ_CTR = 1'b0,
        RQ_EXT = 1'b1
    } rq_kind_e;

    // Single-clock events produced by the cycle decoder
    typedef struct packed {
        logic ctr_start;
        logic ctr_end;
        logic ext_done;
        logic rd_bad;
        logic desel;
        logic rd_start;
        logic any_start;
    } cyc_ev_t;

    function automatic cyc_e classify(input logic rfsh, input logic sel, input logic wr);
        if (rfsh)      return CY_CTR;
        else if (!sel) return CY_BAD;
        else if (wr)   return CY_WR;
        else           return CY_RD;
    endfunction

endpackage

// File: rtl/rfsh_decode.sv
module rfsh_decode
    import rfsh_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_act_i,
    input  logic             col_latch_i,
    input  logic             wr_sel_i,
    input  logic             rfsh_i,
    input  logic             sel_i,
    input  logic [ROW_W-1:0] addr_i,
    output cyc_ev_t          ev_o,
    output cyc_e             cyc_o,
    output logic [ROW_W-1:0] cap_row_o
);
    logic             act_q;
    cyc_e             cyc_q;
    logic             col_q;
    logic [ROW_W-1:0] row_q;
    logic             start;
    logic             fall;
    cyc_e             kind;

    assign start = row_act_i & ~act_q;
    assign fall  = ~row_act_i & act_q;
    assign kind  = classify(rfsh_i, sel_i, wr_sel_i);

    always_comb begin
        ev_o           = '0;
        ev_o.any_start = start;
        ev_o.ctr_start = start & (kind == CY_CTR);
        ev_o.desel     = start & (kind == CY_BAD);
        ev_o.rd_start  = start & (kind == CY_RD);
        ev_o.ctr_end   = fall & (cyc_q == CY_CTR);
        ev_o.ext_done  = fall & (cyc_q == CY_WR) & ~col_q;
        ev_o.rd_bad    = fall & (cyc_q == CY_RD) & ~col_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cyc_q <= CY_IDLE;
            col_q <= 1'b0;
            row_q <= '0;
        end else begin
            act_q <= row_act_i;
            if (start) begin
                cyc_q <= kind;
                col_q <= col_latch_i;
                row_q <= addr_i;
            end else if (row_act_i) begin
                col_q <= col_q | col_latch_i;
            end else if (fall) begin
                cyc_q <= CY_IDLE;
            end
        end
    end

    assign cyc_o     = cyc_q;
    assign cap_row_o = row_q;
endmodule

// File: rtl/rfsh_ctr.sv
module rfsh_ctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (adv_i) cnt_q <= cnt_q + ROW_W'(1);
    end

    assign row_o = cnt_q;
endmodule

// File: rtl/rfsh_wdog.sv
module rfsh_wdog #(
    parameter int WIN_CYC  = 16_000_000,
    parameter int MIN_RFSH = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    output logic viol_o
);
    localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int REF_W = $clog2(MIN_RFSH + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [REF_W:0]   NEED     = (REF_W + 1)'(MIN_RFSH);

    logic [WIN_W-1:0] win_q;
    logic [REF_W-1:0] ref_q;
    logic [REF_W:0]   sum;
    logic             viol_q;

    assign sum = {1'b0, ref_q} + {{REF_W{1'b0}}, hit_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            ref_q  <= '0;
            viol_q <= 1'b0;
        end else if (win_q == WIN_LAST) begin
            win_q  <= '0;
            ref_q  <= '0;
            viol_q <= (sum < NEED);
        end else begin
            win_q <= win_q + WIN_W'(1);
            ref_q <= (sum >= NEED) ? REF_W'(MIN_RFSH) : sum[REF_W-1:0];
        end
    end

    assign viol_o = viol_q;
endmodule

// File: rtl/rfsh_init.sv
module rfsh_init #(
    parameter int ROW_W    = 10,
    parameter int INIT_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rd_start_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             ready_o
);
    localparam int BANK_W = 2;
    localparam int BANKS  = 1 << BANK_W;
    localparam int ACT_W  = $clog2(INIT_CYC + 1);
    localparam logic [ACT_W-1:0] ACT_DONE = ACT_W'(INIT_CYC);

    logic [ACT_W-1:0]  act_q;
    logic              counting;
    logic [BANK_W-1:0] bank;
    logic [BANKS-1:0]  done;

    assign counting = rd_start_i & (act_q == ACT_DONE);
    assign bank     = row_i[ROW_W-1 -: BANK_W];

    always_ff @(posedge clk) begin
        if (rst)                              act_q <= '0;
        else if (start_i && act_q != ACT_DONE) act_q <= act_q + ACT_W'(1);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             seen_q;
        logic             done_q;
        logic [ROW_W-1:0] first_q;
        logic             mine;

        assign mine = counting & (bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                seen_q  <= 1'b0;
                done_q  <= 1'b0;
                first_q <= '0;
            end else if (mine) begin
                if (!seen_q) begin
                    seen_q  <= 1'b1;
                    first_q <= row_i;
                end else if (row_i != first_q) begin
                    done_q <= 1'b1;
                end
            end
        end

        assign done[b] = done_q;
    end

    assign ready_o = (act_q == ACT_DONE) & (&done);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int INIT_CYC = 8,
    parameter int MIN_RFSH = 1024,
    parameter int WIN_CYC  = 16_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_act_i,
    input  logic             col_latch_i,
    input  logic             wr_sel_i,
    input  logic             rfsh_i,
    input  logic             sel_i,
    input  logic [ROW_W-1:0] addr_i,
    output logic             arr_go_o,
    output logic             arr_kind_o,
    output logic [ROW_W-1:0] arr_row_o,
    output logic             tag_wr_ok_o,
    output logic             desel_err_o,
    output logic             rd_rfsh_err_o,
    output logic             viol_o,
    output logic             ready_o
);
    cyc_ev_t          ev;
    cyc_e             cyc;
    logic [ROW_W-1:0] cap_row;
    logic [ROW_W-1:0] ctr_row;

    logic             go_q;
    rq_kind_e         kind_q;
    logic [ROW_W-1:0] row_q;
    logic             desel_q;
    logic             rderr_q;

    rfsh_decode #(.ROW_W(ROW_W)) u_dec (
        .clk(clk), .rst(rst), .row_act_i(row_act_i), .col_latch_i(col_latch_i),
        .wr_sel_i(wr_sel_i), .rfsh_i(rfsh_i), .sel_i(sel_i), .addr_i(addr_i),
        .ev_o(ev), .cyc_o(cyc), .cap_row_o(cap_row)
    );

    rfsh_ctr #(.ROW_W(ROW_W)) u_ctr (
        .clk(clk), .rst(rst), .adv_i(ev.ctr_end), .row_o(ctr_row)
    );

    rfsh_wdog #(.WIN_CYC(WIN_CYC), .MIN_RFSH(MIN_RFSH)) u_wdog (
        .clk(clk), .rst(rst), .hit_i(ev.ctr_start), .viol_o(viol_o)
    );

    rfsh_init #(.ROW_W(ROW_W), .INIT_CYC(INIT_CYC)) u_init (
        .clk(clk), .rst(rst), .start_i(ev.any_start), .rd_start_i(ev.rd_start),
        .row_i(addr_i), .ready_o(ready_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q    <= 1'b0;
            kind_q  <= RQ_CTR;
            row_q   <= '0;
            desel_q <= 1'b0;
            rderr_q <= 1'b0;
        end else begin
            go_q    <= ev.ctr_start | ev.ext_done;
            desel_q <= ev.desel;
            rderr_q <= ev.rd_bad;
            if (ev.ctr_start) begin
                kind_q <= RQ_CTR;
                row_q  <= ctr_row;
            end else if (ev.ext_done) begin
                kind_q <= RQ_EXT;
                row_q  <= cap_row;
            end
        end
    end

    assign arr_go_o      = go_q;
    assign arr_kind_o    = kind_q;
    assign arr_row_o     = row_q;
    assign desel_err_o   = desel_q;
    assign rd_rfsh_err_o = rderr_q;
    assign tag_wr_ok_o   = (cyc == CY_RD);
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
    parameter int ROW_W    = 10,
    parameter int INIT_CYC = 8,
    parameter int WIN_CYC  = 16_000_000
) (
    input logic             clk,
    input logic             rst,
    input logic             row_act_i,
    input logic             sel_i,
    input logic             arr_go_o,
    input logic             arr_kind_o,
    input logic [ROW_W-1:0] arr_row_o,
    input logic             tag_wr_ok_o,
    input logic             desel_err_o,
    input logic             viol_o,
    input logic             ready_o
);
    localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int ACT_W = $clog2(INIT_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [ACT_W-1:0] ACT_DONE = ACT_W'(INIT_CYC);

    logic             prev_act_q;
    logic [ACT_W-1:0] starts_q;
    logic [WIN_W-1:0] win_q;
    logic [ROW_W-1:0] last_q;
    logic             have_last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_act_q  <= 1'b0;
            starts_q    <= '0;
            win_q       <= '0;
            last_q      <= '0;
            have_last_q <= 1'b0;
        end else begin
            prev_act_q <= row_act_i;
            if (row_act_i && !prev_act_q && starts_q != ACT_DONE)
                starts_q <= starts_q + ACT_W'(1);
            win_q <= (win_q == WIN_LAST) ? '0 : win_q + WIN_W'(1);
            if (arr_go_o && !arr_kind_o) begin
                last_q      <= arr_row_o;
                have_last_q <= 1'b1;
            end
        end
    end

    // R2
    ctr_row_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_go_o && !arr_kind_o && have_last_q) |-> (arr_row_o == last_q + ROW_W'(1)));

    // R4
    tag_refresh_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_go_o && !arr_kind_o) |-> !tag_wr_ok_o);

    // R3
    ext_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_go_o && arr_kind_o) |-> $past(!row_act_i));

    // R5
    desel_cause_chk: assert property (@(posedge clk) disable iff (rst)
        desel_err_o |-> $past(!sel_i));

    // R7
    viol_window_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(viol_o) |-> (win_q == '0));

    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(ready_o));

    // R8
    ready_after_init_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (starts_q == ACT_DONE));
endmodule

bind rfsh_seq rfsh_seq_chk #(
    .ROW_W(ROW_W), .INIT_CYC(INIT_CYC), .WIN_CYC(WIN_CYC)
) u_chk (
    .clk(clk), .rst(rst), .row_act_i(row_act_i), .sel_i(sel_i),
    .arr_go_o(arr_go_o), .arr_kind_o(arr_kind_o), .arr_row_o(arr_row_o),
    .tag_wr_ok_o(tag_wr_ok_o), .desel_err_o(desel_err_o),
    .viol_o(viol_o), .ready_o(ready_o)
);

// File: tb/rfsh_seq_tb.sv
`timescale 1ns/1ps
module rfsh_seq_tb;
    localparam int RW   = 4;
    localparam int INIT = 8;
    localparam int MINR = 3;
    localparam int WIN  = 200;
    localparam int NROW = 1 << RW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_act = 0, col = 0, wr = 0, rf = 0, sel = 1;
    logic [RW-1:0] addr = '0;
    logic go, kind, tag, desel, rderr, viol, ready;
    logic [RW-1:0] row;

    always #2 clk = ~clk;

    rfsh_seq #(.ROW_W(RW), .INIT_CYC(INIT), .MIN_RFSH(MINR), .WIN_CYC(WIN)) u_dut (
        .clk(clk), .rst(rst), .row_act_i(row_act), .col_latch_i(col), .wr_sel_i(wr),
        .rfsh_i(rf), .sel_i(sel), .addr_i(addr), .arr_go_o(go), .arr_kind_o(kind),
        .arr_row_o(row), .tag_wr_ok_o(tag), .desel_err_o(desel), .rd_rfsh_err_o(rderr),
        .viol_o(viol), .ready_o(ready)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    bit cmp_en = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_prev, m_type, m_col, m_row, m_cnt, m_acts, m_win, m_ref;
    int m_seen[4], m_first[4], m_done[4];
    bit e_go, e_kind, e_desel, e_rderr, e_viol, e_tag, e_ready;
    int e_row;

    always @(posedge clk) begin
        if (rst) begin
            m_prev = 0; m_type = 0; m_col = 0; m_row = 0; m_cnt = 0; m_acts = 0;
            m_win = 0; m_ref = 0;
            for (int b = 0; b < 4; b++) begin m_seen[b] = 0; m_first[b] = 0; m_done[b] = 0; end
            e_go = 0; e_kind = 0; e_row = 0; e_desel = 0; e_rderr = 0; e_viol = 0;
            e_tag = 0; e_ready = 0;
        end else begin
            int hit;
            hit = 0; e_go = 0; e_desel = 0; e_rderr = 0;
            if (row_act && !m_prev) begin
                if (rf) begin e_go = 1; e_kind = 0; e_row = m_cnt; m_type = 1; hit = 1; end
                else if (!sel) begin e_desel = 1; m_type = 4; end
                else if (wr) m_type = 2;
                else begin
                    m_type = 3;
                    if (m_acts >= INIT) begin
                        int b, r;
                        r = int'(addr); b = r / 4;
                        if (!m_seen[b]) begin m_seen[b] = 1; m_first[b] = r; end
                        else if (r != m_first[b]) m_done[b] = 1;
                    end
                end
                m_col = col; m_row = int'(addr);
                if (m_acts < INIT) m_acts++;
            end else if (row_act && m_prev) begin
                m_col = m_col | int'(col);
            end else if (!row_act && m_prev) begin
                if (m_type == 1) m_cnt = (m_cnt + 1) % NROW;
                if (m_type == 2 && !m_col) begin e_go = 1; e_kind = 1; e_row = m_row; end
                if (m_type == 3 && !m_col) e_rderr = 1;
                m_type = 0;
            end
            m_prev = row_act;
            if (m_win == WIN - 1) begin
                e_viol = ((m_ref + hit) < MINR); m_win = 0; m_ref = 0;
            end else begin
                m_win++; m_ref += hit;
            end
            e_tag = (m_type == 3);
            e_ready = (m_acts >= INIT) && m_done[0] && m_done[1] && m_done[2] && m_done[3];
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk("R1 R3", "arr_go", go, e_go);
            if (e_go) begin
                chk("R2 R3", "arr_row", row, e_row);
                chk("R1 R3", "arr_kind", kind, e_kind);
            end
            chk("R4", "tag_wr_ok", tag, e_tag);
            chk("R5", "desel_err", desel, e_desel);
            chk("R6", "rd_rfsh_err", rderr, e_rderr);
            chk("R7", "viol", viol, e_viol);
            chk("R8", "ready", ready, e_ready);
        end
    end

    // Snapshots taken inside a cycle
    logic s_go, s_desel, s_tag, f_go, f_rderr, f_kind;
    logic [RW-1:0] s_row, f_row;
    int nref = 0;

    task automatic run_cyc(input bit r, input bit s, input bit w, input int a, input bit use_col);
        @(negedge clk);
        row_act = 1; rf = r; sel = s; wr = w; addr = RW'(a); col = 0;
        @(negedge clk);
        s_go = go; s_row = row; s_desel = desel; s_tag = tag;
        col = use_col; addr = RW'(a + 5); wr = ~w;
        @(negedge clk);
        col = 0; rf = 0; sel = 1;
        @(negedge clk);
        row_act = 0;
        @(negedge clk);
        f_go = go; f_row = row; f_rderr = rderr; f_kind = kind;
        if (r) nref++;
    endtask

    task automatic ctr_ref(input int a);
        run_cyc(1, 1, 0, a, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs cleared under reset
        chk("R9", "go in reset", go, 0);
        chk("R9", "tag in reset", tag, 0);
        chk("R9", "viol in reset", viol, 0);
        chk("R9", "ready in reset", ready, 0);
        rst = 0;
        cmp_en = 1;
        @(negedge clk);
        chk("R9", "errors after reset", desel | rderr, 0);

        // Seven counter refreshes with varied ignored inputs (R1)
        for (int i = 0; i < 7; i++) begin
            run_cyc(1, i[0], i[1], 15 - i, i[2]);
            chk("R1", "counter refresh request", s_go, 1);
            chk("R1", "counter refresh row", s_row, (nref - 1) % NROW);
            chk("R5", "deselected counter refresh no error", s_desel, 0);
            chk("R4", "no tag permit in refresh", s_tag, 0);
        end
        // Eighth start: a read that does not count toward bank init (R8)
        run_cyc(0, 1, 0, 0, 1);
        chk("R4", "tag permit in read", s_tag, 1);
        run_cyc(0, 1, 0, 1, 1);
        run_cyc(0, 1, 0, 1, 1);
        chk("R8", "not ready after same-row reads", ready, 0);
        run_cyc(0, 1, 0, 0, 1);
        for (int b = 1; b < 4; b++) begin
            run_cyc(0, 1, 0, b * 4, 1);
            if (b == 3) chk("R8", "not ready before last bank", ready, 0);
            run_cyc(0, 1, 0, b * 4 + 1, 1);
        end
        chk("R8", "ready after all banks", ready, 1);

        // Addressed refresh (R3)
        run_cyc(0, 1, 1, 13, 0);
        chk("R3", "addressed refresh request", f_go, 1);
        chk("R3", "addressed refresh kind", f_kind, 1);
        chk("R3", "addressed refresh row", f_row, 13);
        chk("R4", "no tag permit in write", s_tag, 0);
        run_cyc(0, 1, 1, 6, 1);
        chk("R3", "write with column makes no request", f_go, 0);

        // Deselected read and write (R5)
        run_cyc(0, 0, 0, 2, 1);
        chk("R5", "deselected read flagged", s_desel, 1);
        chk("R4", "deselected read no tag", s_tag, 0);
        run_cyc(0, 0, 1, 3, 0);
        chk("R5", "deselected write no request", f_go, 0);

        // Read without column (R6)
        run_cyc(0, 1, 0, 9, 0);
        chk("R6", "read without column flagged", f_rderr, 1);
        run_cyc(0, 1, 0, 9, 1);
        chk("R6", "read with column clean", f_rderr, 0);

        // Counter wrap (R2)
        for (int i = 0; i < 20; i++) begin
            ctr_ref(i);
            chk("R2", "counter row sequence", s_row, (nref - 1) % NROW);
        end
        chk("R8", "ready held", ready, 1);

        // Watchdog (R7)
        repeat (450) @(negedge clk);
        chk("R7", "violation after idle window", viol, 1);
        for (int i = 0; i < 60; i++) ctr_ref(i);
        chk("R7", "no violation with enough refreshes", viol, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule